// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers the event flags of a CAN controller and reduces them to four level-sensitive interrupt request lines. The lines are transmit, receive FIFO 0, receive FIFO 1, and a combined error/status-change line. A single 32-bit interrupt-enable word gates every source. Each enable bit passes exactly one condition through to its line.

Mailbox and FIFO flags are live levels that other logic owns. The error condition feeds a sticky summary flag. That flag is built from four separately enabled sub-conditions, one of which is a range test on the 3-bit last-error code. Wakeup and sleep-acknowledge events are also held in sticky flags. Software clears each of the three sticky flags with a one-cycle write-one-to-clear pulse.

All pins are plain control and status levels, with no streaming handshake. Every interrupt output is registered.

Top module: `can_irq_agg`

## Requirements
- R1: `irq_tx` is 1 one clock after a cycle where enable bit 0 is 1 and at least one of the three `tx_done` bits is 1; otherwise it is 0 one clock later.
- R2: `irq_rx0` is the registered OR of three terms: enable bit 4 AND (`rx0_pend` != 0), enable bit 5 AND `rx0_full`, and enable bit 6 AND `rx0_ovr`.
- R3: `irq_rx1` has the same structure as R2 using enable bits 8, 9 and 10 and the `rx1_*` inputs, and it is unaffected by FIFO 0 inputs or enables.
- R4: `err_flag` is set after any cycle in which at least one of these is true: enable bit 12 AND `err_warn`, enable bit 13 AND `err_pass`, enable bit 14 AND `bus_off`, or enable bit 15 AND 1 <= `lec` <= 6.
- R5: A `lec` value of 0 or 7 never sets `err_flag`.
- R6: `err_flag` holds its value until an `err_clr` pulse clears it. If a set condition and `err_clr` occur in the same cycle, the flag ends up 1.
- R7: `wake_flag` is set by `wake_evt` and `slack_flag` is set by `slack_evt`. Each holds until its own clear pulse (`wake_clr` or `slack_clr`), and a set wins over a clear in the same cycle.
- R8: One clock after a cycle, `irq_sce` equals (enable bit 20 AND `err_flag`) OR (enable bit 24 AND `wake_flag`) OR (enable bit 25 AND `slack_flag`), where each flag is the value it holds after that same edge.
- R9: Each interrupt output changes exactly one clock after the inputs that cause it and stays at its level for as long as the cause remains.
- R10: While `rst_n` is 0 at a rising edge, all sticky flags and all four interrupt outputs are 0 after that edge, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ie_word | input | 32 | Interrupt-enable word |
| tx_done | input | 3 | Mailbox request-complete flags |
| rx0_pend | input | 2 | FIFO 0 pending-message count |
| rx0_full | input | 1 | FIFO 0 full |
| rx0_ovr | input | 1 | FIFO 0 overrun |
| rx1_pend | input | 2 | FIFO 1 pending-message count |
| rx1_full | input | 1 | FIFO 1 full |
| rx1_ovr | input | 1 | FIFO 1 overrun |
| err_warn | input | 1 | Error-warning flag |
| err_pass | input | 1 | Error-passive flag |
| bus_off | input | 1 | Bus-off flag |
| lec | input | 3 | Last-error code |
| wake_evt | input | 1 | Wakeup event |
| slack_evt | input | 1 | Sleep-acknowledge event |
| err_clr | input | 1 | Clear pulse for the error summary flag |
| wake_clr | input | 1 | Clear pulse for the wakeup flag |
| slack_clr | input | 1 | Clear pulse for the sleep-acknowledge flag |
| err_flag | output | 1 | Sticky error summary flag |
| wake_flag | output | 1 | Sticky wakeup flag |
| slack_flag | output | 1 | Sticky sleep-acknowledge flag |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx0 | output | 1 | FIFO 0 interrupt |
| irq_rx1 | output | 1 | FIFO 1 interrupt |
| irq_sce | output | 1 | Error/status-change interrupt |

## Verification
Every result appears one clock after the inputs that cause it. This holds for the sticky flags and for all four interrupt lines, including `irq_sce`, which is driven from the next values of the sticky flags.

The bench changes inputs on the falling edge. It computes the expected state from those inputs and the model flags, and compares all seven outputs on the following falling edge, so exactly one rising edge falls between stimulus and check. Directed cases cover each source with its enable on and off, `lec` values 0, 6 and 7, and set-against-clear collisions.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int IE_W         = 32;
  localparam int N_MBOX       = 3;
  localparam int PEND_W       = 2;
  localparam int LEC_W        = 3;
  localparam int LEC_LO       = 1;
  localparam int LEC_HI       = 6;
  localparam int N_FIFO       = 2;

  // enable bit positions
  localparam int IE_TX        = 0;
  localparam int IE_RX_BASE   = 4;
  localparam int IE_RX_STRIDE = 4;
  localparam int IE_RX_PEND   = 0;
  localparam int IE_RX_FULL   = 1;
  localparam int IE_RX_OVR    = 2;
  localparam int IE_WARN      = 12;
  localparam int IE_PASS      = 13;
  localparam int IE_BOFF      = 14;
  localparam int IE_LEC       = 15;
  localparam int IE_ERR       = 20;
  localparam int IE_WAKE      = 24;
  localparam int IE_SLACK     = 25;

  typedef struct packed {
    logic pend_en;
    logic full_en;
    logic ovr_en;
  } rx_en_t;

  typedef struct packed {
    logic warn_en;
    logic pass_en;
    logic boff_en;
    logic lec_en;
  } err_en_t;
endpackage

// File: rtl/can_irq_tx_gate.sv
module can_irq_tx_gate #(
  parameter int N_MBOX = 3
) (
  input  logic              en,
  input  logic [N_MBOX-1:0] done,
  output logic              req
);
  always_comb req = en & (|done);
endmodule

// File: rtl/can_irq_fifo_gate.sv
module can_irq_fifo_gate
  import can_irq_pkg::*;
#(
  parameter int PW = 2
) (
  input  rx_en_t        en,
  input  logic [PW-1:0] pend,
  input  logic          full,
  input  logic          ovr,
  output logic          req
);
  logic pend_hit;
  always_comb begin
    pend_hit = (pend != '0);
    req      = (en.pend_en & pend_hit) | (en.full_en & full) | (en.ovr_en & ovr);
  end
endmodule

// File: rtl/can_irq_sce.sv
module can_irq_sce
  import can_irq_pkg::*;
#(
  parameter int LW = 3,
  parameter int LO = 1,
  parameter int HI = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  err_en_t       en,
  input  logic          err_gate,
  input  logic          wake_en,
  input  logic          slack_en,
  input  logic          warn,
  input  logic          pass,
  input  logic          boff,
  input  logic [LW-1:0] lec,
  input  logic          wake_evt,
  input  logic          slack_evt,
  input  logic          err_clr,
  input  logic          wake_clr,
  input  logic          slack_clr,
  output logic          err_flag,
  output logic          wake_flag,
  output logic          slack_flag,
  output logic          sce_req
);
  localparam logic [LW-1:0] LO_V = LW'(LO);
  localparam logic [LW-1:0] HI_V = LW'(HI);

  logic lec_hit, err_set;
  logic err_nxt, wake_nxt, slack_nxt;

  always_comb begin
    lec_hit   = (lec >= LO_V) && (lec <= HI_V);
    err_set   = (en.warn_en & warn) | (en.pass_en & pass) |
                (en.boff_en & boff) | (en.lec_en & lec_hit);
    err_nxt   = err_set   | (err_flag   & ~err_clr);
    wake_nxt  = wake_evt  | (wake_flag  & ~wake_clr);
    slack_nxt = slack_evt | (slack_flag & ~slack_clr);
    sce_req   = (err_gate & err_nxt) | (wake_en & wake_nxt) | (slack_en & slack_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag   <= 1'b0;
      wake_flag  <= 1'b0;
      slack_flag <= 1'b0;
    end else begin
      err_flag   <= err_nxt;
      wake_flag  <= wake_nxt;
      slack_flag <= slack_nxt;
    end
  end
endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IE_W-1:0]   ie_word,
  input  logic [N_MBOX-1:0] tx_done,
  input  logic [PEND_W-1:0] rx0_pend,
  input  logic              rx0_full,
  input  logic              rx0_ovr,
  input  logic [PEND_W-1:0] rx1_pend,
  input  logic              rx1_full,
  input  logic              rx1_ovr,
  input  logic              err_warn,
  input  logic              err_pass,
  input  logic              bus_off,
  input  logic [LEC_W-1:0]  lec,
  input  logic              wake_evt,
  input  logic              slack_evt,
  input  logic              err_clr,
  input  logic              wake_clr,
  input  logic              slack_clr,
  output logic              err_flag,
  output logic              wake_flag,
  output logic              slack_flag,
  output logic              irq_tx,
  output logic              irq_rx0,
  output logic              irq_rx1,
  output logic              irq_sce
);
  logic [N_FIFO-1:0][PEND_W-1:0] pend_a;
  logic [N_FIFO-1:0]             full_a, ovr_a, rx_req;
  logic                          tx_req, sce_req;
  logic [N_FIFO-1:0]             irq_rx_q;
  logic                          ie_unused;
  err_en_t                       err_en;

  assign ie_unused = ^ie_word;

  assign pend_a = {rx1_pend, rx0_pend};
  assign full_a = {rx1_full, rx0_full};
  assign ovr_a  = {rx1_ovr,  rx0_ovr};

  can_irq_tx_gate #(.N_MBOX(N_MBOX)) u_tx (
    .en   (ie_word[IE_TX]),
    .done (tx_done),
    .req  (tx_req)
  );

  for (genvar gi = 0; gi < N_FIFO; gi++) begin : g_fifo
    localparam int BASE = IE_RX_BASE + gi * IE_RX_STRIDE;
    rx_en_t en_f;
    assign en_f.pend_en = ie_word[BASE + IE_RX_PEND];
    assign en_f.full_en = ie_word[BASE + IE_RX_FULL];
    assign en_f.ovr_en  = ie_word[BASE + IE_RX_OVR];
    can_irq_fifo_gate #(.PW(PEND_W)) u_gate (
      .en   (en_f),
      .pend (pend_a[gi]),
      .full (full_a[gi]),
      .ovr  (ovr_a[gi]),
      .req  (rx_req[gi])
    );
  end

  assign err_en.warn_en = ie_word[IE_WARN];
  assign err_en.pass_en = ie_word[IE_PASS];
  assign err_en.boff_en = ie_word[IE_BOFF];
  assign err_en.lec_en  = ie_word[IE_LEC];

  can_irq_sce #(.LW(LEC_W), .LO(LEC_LO), .HI(LEC_HI)) u_sce (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (err_en),
    .err_gate   (ie_word[IE_ERR]),
    .wake_en    (ie_word[IE_WAKE]),
    .slack_en   (ie_word[IE_SLACK]),
    .warn       (err_warn),
    .pass       (err_pass),
    .boff       (bus_off),
    .lec        (lec),
    .wake_evt   (wake_evt),
    .slack_evt  (slack_evt),
    .err_clr    (err_clr),
    .wake_clr   (wake_clr),
    .slack_clr  (slack_clr),
    .err_flag   (err_flag),
    .wake_flag  (wake_flag),
    .slack_flag (slack_flag),
    .sce_req    (sce_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_tx   <= 1'b0;
      irq_rx_q <= '0;
      irq_sce  <= 1'b0;
    end else begin
      irq_tx   <= tx_req;
      irq_rx_q <= rx_req;
      irq_sce  <= sce_req;
    end
  end

  assign irq_rx0 = irq_rx_q[0];
  assign irq_rx1 = irq_rx_q[1];
endmodule

// File: rtl/can_irq_agg_chk.sv
module can_irq_agg_chk
  import can_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [IE_W-1:0]   ie_word,
  input logic [N_MBOX-1:0] tx_done,
  input logic [PEND_W-1:0] rx0_pend,
  input logic              rx1_full,
  input logic              wake_evt,
  input logic              err_clr,
  input logic              err_flag,
  input logic              wake_flag,
  input logic              irq_tx,
  input logic              irq_rx0,
  input logic              irq_rx1,
  input logic              irq_sce
);
  // R1
  tx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_word[IE_TX] && (tx_done != '0)) |=> irq_tx);
  // R1
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_word[IE_TX] |=> !irq_tx);
  // R2
  rx0_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_word[IE_RX_BASE + IE_RX_PEND] && (rx0_pend != '0)) |=> irq_rx0);
  // R3
  rx1_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_word[IE_RX_BASE + IE_RX_STRIDE + IE_RX_FULL] && rx1_full) |=> irq_rx1);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  // R7
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wake_flag);
  // R8
  sce_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_word[IE_WAKE] && wake_evt) |=> irq_sce);
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_tx && !irq_rx0 && !irq_rx1 && !irq_sce && !err_flag && !wake_flag));
endmodule

bind can_irq_agg can_irq_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ie_word   (ie_word),
  .tx_done   (tx_done),
  .rx0_pend  (rx0_pend),
  .rx1_full  (rx1_full),
  .wake_evt  (wake_evt),
  .err_clr   (err_clr),
  .err_flag  (err_flag),
  .wake_flag (wake_flag),
  .irq_tx    (irq_tx),
  .irq_rx0   (irq_rx0),
  .irq_rx1   (irq_rx1),
  .irq_sce   (irq_sce)
);

// File: tb/can_irq_agg_tb.sv
module can_irq_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ie_word = '0;
  logic [2:0]  tx_done = '0;
  logic [1:0]  rx0_pend = '0, rx1_pend = '0;
  logic        rx0_full = 0, rx0_ovr = 0, rx1_full = 0, rx1_ovr = 0;
  logic        err_warn = 0, err_pass = 0, bus_off = 0;
  logic [2:0]  lec = '0;
  logic        wake_evt = 0, slack_evt = 0, err_clr = 0, wake_clr = 0, slack_clr = 0;
  logic        err_flag, wake_flag, slack_flag, irq_tx, irq_rx0, irq_rx1, irq_sce;

  int tests = 0, fails = 0;
  bit done = 0;
  logic m_err = 0, m_wake = 0, m_slack = 0;
  logic e_tx = 0, e_rx0 = 0, e_rx1 = 0, e_sce = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_agg u_dut (.*);

  function automatic logic f_rx(logic [1:0] p, logic f, logic o, int base);
    return (ie_word[base] && p != 0) || (ie_word[base+1] && f) || (ie_word[base+2] && o);
  endfunction

  function automatic logic f_err_set();
    return (ie_word[12] && err_warn) || (ie_word[13] && err_pass) ||
           (ie_word[14] && bus_off) || (ie_word[15] && lec >= 1 && lec <= 6);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compute expectations from current inputs, cross one rising edge, check
  task automatic step();
    if (!rst_n) begin
      m_err = 0; m_wake = 0; m_slack = 0;
      e_tx = 0; e_rx0 = 0; e_rx1 = 0; e_sce = 0;
    end else begin
      m_err   = f_err_set() || (m_err && !err_clr);
      m_wake  = wake_evt || (m_wake && !wake_clr);
      m_slack = slack_evt || (m_slack && !slack_clr);
      e_tx  = ie_word[0] && (tx_done != 0);
      e_rx0 = f_rx(rx0_pend, rx0_full, rx0_ovr, 4);
      e_rx1 = f_rx(rx1_pend, rx1_full, rx1_ovr, 8);
      e_sce = (ie_word[20] && m_err) || (ie_word[24] && m_wake) || (ie_word[25] && m_slack);
    end
    @(negedge clk);
    chk("R1", "irq_tx", irq_tx, e_tx);
    chk("R2", "irq_rx0", irq_rx0, e_rx0);
    chk("R3", "irq_rx1", irq_rx1, e_rx1);
    chk("R4", "err_flag", err_flag, m_err);
    chk("R7", "wake_flag", wake_flag, m_wake);
    chk("R7", "slack_flag", slack_flag, m_slack);
    chk("R8", "irq_sce", irq_sce, e_sce);
  endtask

  task automatic idle();
    tx_done = 0; rx0_pend = 0; rx1_pend = 0; rx0_full = 0; rx0_ovr = 0;
    rx1_full = 0; rx1_ovr = 0; err_warn = 0; err_pass = 0; bus_off = 0; lec = 0;
    wake_evt = 0; slack_evt = 0; err_clr = 0; wake_clr = 0; slack_clr = 0;
  endtask

  task automatic clear_all();
    idle(); err_clr = 1; wake_clr = 1; slack_clr = 1; step(); idle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R10: reset with every source active and all enables on
    ie_word = '1; tx_done = '1; rx0_pend = 3; rx1_full = 1; err_warn = 1;
    wake_evt = 1; slack_evt = 1; lec = 3;
    step(); step();
    chk("R10", "irq_sce in reset", irq_sce, 1'b0);
    rst_n = 1; idle(); ie_word = '0;
    step();

    // sweep each source with its enable on then off (R1,R2,R3,R4,R8)
    for (int s = 0; s < 13; s++) begin
      for (int on = 1; on >= 0; on--) begin
        clear_all();
        ie_word = '0;
        ie_word[20] = 1; ie_word[24] = 1; ie_word[25] = 1;
        case (s)
          0:  begin tx_done = 3'b100; ie_word[0] = on[0]; end
          1:  begin rx0_pend = 2'd1; ie_word[4] = on[0]; end
          2:  begin rx0_full = 1; ie_word[5] = on[0]; end
          3:  begin rx0_ovr = 1; ie_word[6] = on[0]; end
          4:  begin rx1_pend = 2'd2; ie_word[8] = on[0]; end
          5:  begin rx1_full = 1; ie_word[9] = on[0]; end
          6:  begin rx1_ovr = 1; ie_word[10] = on[0]; end
          7:  begin err_warn = 1; ie_word[12] = on[0]; end
          8:  begin err_pass = 1; ie_word[13] = on[0]; end
          9:  begin bus_off = 1; ie_word[14] = on[0]; end
          10: begin lec = 3'd6; ie_word[15] = on[0]; end
          11: begin wake_evt = 1; ie_word[24] = on[0]; end
          default: begin slack_evt = 1; ie_word[25] = on[0]; end
        endcase
        step();
        idle();
        step(); // R9: held levels / sticky remain one more cycle
      end
    end

    // R5: lec 0 and 7 never set the summary
    clear_all(); ie_word = '0; ie_word[15] = 1; ie_word[20] = 1;
    lec = 3'd7; step(); chk("R5", "lec=7 err_flag", err_flag, 1'b0);
    lec = 3'd0; step(); chk("R5", "lec=0 err_flag", err_flag, 1'b0);
    lec = 3'd1; step(); chk("R4", "lec=1 err_flag", err_flag, 1'b1);

    // R6: hold, then set wins over clear, then clear
    idle(); step(); chk("R6", "err hold", err_flag, 1'b1);
    err_warn = 1; ie_word[12] = 1; err_clr = 1; step();
    chk("R6", "set beats clear", err_flag, 1'b1);
    idle(); err_clr = 1; step(); chk("R6", "cleared", err_flag, 1'b0);
    chk("R8", "sce drops after clear", irq_sce, 1'b0);

    // R7: wake set and clear in same cycle
    idle(); wake_evt = 1; wake_clr = 1; step(); chk("R7", "wake set wins", wake_flag, 1'b1);
    idle(); slack_evt = 1; slack_clr = 1; step(); chk("R7", "slack set wins", slack_flag, 1'b1);
    idle(); wake_clr = 1; slack_clr = 1; step();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      ie_word   = $urandom();
      tx_done   = (($urandom() % 4) == 0) ? 3'($urandom()) : 3'd0;
      rx0_pend  = (($urandom() % 3) == 0) ? 2'($urandom()) : 2'd0;
      rx1_pend  = (($urandom() % 3) == 0) ? 2'($urandom()) : 2'd0;
      rx0_full  = (($urandom() % 5) == 0);
      rx0_ovr   = (($urandom() % 5) == 0);
      rx1_full  = (($urandom() % 5) == 0);
      rx1_ovr   = (($urandom() % 5) == 0);
      err_warn  = (($urandom() % 8) == 0);
      err_pass  = (($urandom() % 8) == 0);
      bus_off   = (($urandom() % 8) == 0);
      lec       = (($urandom() % 3) == 0) ? 3'($urandom()) : 3'd0;
      wake_evt  = (($urandom() % 10) == 0);
      slack_evt = (($urandom() % 10) == 0);
      err_clr   = (($urandom() % 4) == 0);
      wake_clr  = (($urandom() % 4) == 0);
      slack_clr = (($urandom() % 4) == 0);
      if (n == 1500) rst_n = 0;
      if (n == 1502) rst_n = 1;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule